// File: doc/BRIEF.md
# Serial Flash Status Register with Write Protection

This block is the device side of a serial flash status register. It sits behind an SPI target port (mode 0, MSB first) and takes a hardware protect pin. It understands four commands: read status, write enable, enable-status-write and status write. It holds a lock bit, a two-bit protection field, an error flag, a write-enable latch and a busy flag, and it decides which of these a status write may change.

A host reads the register by sending the read-status opcode and clocking further bytes. To change protection, the host first sends the enabling command chosen by the `ENABLE_MODE` parameter and then a status write with one data byte. An accepted write starts a self-timed internal operation of `BUSY_CYCLES` clocks. New field values only take effect when that operation ends. A set lock bit freezes the protection field. The lock cannot be released while the protect pin is held low.

Top module: `sflash_status_guard`

## Requirements
- R1: After reset, with `hw_protect_n` high, the status byte reads 0x1C: lock bit 7 = 0, bit 6 = 0, error bit 5 = 0, bit 4 = 1, protection field bits 3:2 = 11, write-enable latch bit 1 = 0, busy bit 0 = 0.
- R2: Read status (opcode 0x05, SPI mode 0, MSB first) returns the status byte on `spi_miso` for the first byte after the opcode and again for each further byte while `spi_cs_n` stays low.
- R3: Status bit 4 follows the level of `hw_protect_n` (1 = pin high, not protecting).
- R4: A frame holding only the write-enable opcode 0x06 sets the write-enable latch (bit 1) when `spi_cs_n` rises.
- R5: A status write (opcode 0x01 followed by one data byte) is accepted only if enabled. `ENABLE_MODE` 0 requires the write-enable latch. Mode 1 requires a prior enable-status-write frame (opcode 0x50). Mode 2 accepts either. A write that is not enabled changes no field, does not start busy, and clears the write-enable latch.
- R6: An accepted status write sets busy (bit 0) for `BUSY_CYCLES` clocks. During that time the old field values and the write-enable latch stay visible. At the end the new values take effect, and the write-enable latch and the error flag clear.
- R7: Writing 00 into bits 3:2 clears all protection and writing 11 protects all. A value of 01 or 10 leaves the field unchanged.
- R8: While the lock bit is set, a status write can change only bit 7 and the protection field is frozen. When the protect pin is high, a write with bit 7 = 0 releases the lock and nothing else.
- R9: A write that would release the lock while `hw_protect_n` is low is refused: lock and protection field stay unchanged, busy does not start, the write-enable latch clears and the error flag (bit 5) sets.
- R10: While busy, write-enable, enable-status-write and status-write frames are ignored, but read status still works and shows busy = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host, sampled on SCK rise |
| hw_protect_n | input | 1 | Hardware protect pin, active low |
| spi_miso | output | 1 | Serial data to host, changes after SCK fall, 0 while deselected |

## Verification
The assertions assume the SPI pins move slowly compared to `clk`: each SCK phase lasts several clocks, so the synchronizers see every edge, and MOSI is stable around each rising edge. The stimulus holds each SCK half period for eight clocks and changes MOSI and chip select only while SCK is low. It also leaves a gap of idle clocks after each frame, so that the decoded command reaches the register before the next frame starts. The protect pin changes only between frames.

// File: rtl/sfsg_pkg.sv
// Shared constants and types for the status-register protection block.
// Assumes byte-wide SPI commands and a fixed status bit layout.
package sfsg_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_READ_STATUS  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRITE_ENABLE = 8'h06;
    localparam logic [BYTE_W-1:0] OP_STATUS_EN    = 8'h50;
    localparam logic [BYTE_W-1:0] OP_WRITE_STATUS = 8'h01;

    // Which enabling command a status write requires.
    typedef enum logic [1:0] {
        EN_BY_WREN   = 2'd0,
        EN_BY_STATUS = 2'd1,
        EN_BY_EITHER = 2'd2
    } enable_mode_e;

    // Command classified when a frame ends.
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_WREN   = 2'd1,
        CMD_SEN    = 2'd2,
        CMD_WRSTAT = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/sfsg_spi_link.sv
// SPI mode-0 target link: synchronizes the pins into clk, assembles bytes
// MSB first on SCK rise and shifts a reply byte out after SCK fall.
// Assumes each SCK phase lasts at least SYNC_STAGES+1 clk cycles.
module sfsg_spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       cs_n,
    input  logic                       mosi,
    input  logic                       tx_load,
    input  logic [sfsg_pkg::BYTE_W-1:0] tx_byte,
    output logic                       miso,
    output logic                       frame_start,
    output logic                       frame_end,
    output logic                       rx_valid,
    output logic [sfsg_pkg::BYTE_W-1:0] rx_byte
);
    import sfsg_pkg::*;

    localparam int BIT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES:0]   cs_p;
    logic [SYNC_STAGES-1:0] mosi_p;
    logic [BIT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      rx_sh;
    logic [BYTE_W-1:0]      tx_sh;

    logic sck_now, sck_old, cs_now, cs_old, mosi_s;
    logic sck_rise, sck_fall, active;

    // Synchronizer chains with one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[SYNC_STAGES-1:0], sck};
            cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
        end
    end

    // Edge decode of the synchronized pins.
    always_comb begin
        sck_now     = sck_p[SYNC_STAGES-1];
        sck_old     = sck_p[SYNC_STAGES];
        cs_now      = cs_p[SYNC_STAGES-1];
        cs_old      = cs_p[SYNC_STAGES];
        mosi_s      = mosi_p[SYNC_STAGES-1];
        sck_rise    = sck_now & ~sck_old;
        sck_fall    = ~sck_now & sck_old;
        frame_start = ~cs_now & cs_old;
        frame_end   = cs_now & ~cs_old;
        active      = ~cs_now;
    end

    // Receive shifter: one bit per SCK rise, byte strobe after the eighth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
            end else if (active && sck_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh[BYTE_W-2:0], mosi_s};
                end
            end
        end
    end

    // Transmit shifter: load at a byte boundary, shift on SCK fall inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (frame_start) begin
            tx_sh <= '0;
        end else if (tx_load) begin
            tx_sh <= tx_byte;
        end else if (active && sck_fall && bit_cnt != '0) begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = active ? tx_sh[BYTE_W-1] : 1'b0;

    // R2: a byte strobe always coincides with a wrapped bit counter.
    p_byte_framing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (bit_cnt == '0));
endmodule

// File: rtl/sfsg_cmd_decode.sv
// Frame decoder: captures opcode and first data byte, requests the reply for
// read status, and classifies the command when chip select rises.
// Assumes frame_start/frame_end/rx_valid never coincide.
module sfsg_cmd_decode (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        frame_end,
    input  logic                        rx_valid,
    input  logic [sfsg_pkg::BYTE_W-1:0] rx_byte,
    output logic                        tx_load,
    output logic                        cmd_valid,
    output sfsg_pkg::cmd_kind_e         cmd_kind,
    output logic                        cmd_lock,
    output logic [1:0]                  cmd_prot
);
    import sfsg_pkg::*;

    logic [1:0]        byte_cnt;
    logic [BYTE_W-1:0] opcode;
    logic              data_lock;
    logic [1:0]        data_prot;
    cmd_kind_e         kind_c;

    // Byte counter (saturating) and capture of opcode and data fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt  <= '0;
            opcode    <= '0;
            data_lock <= 1'b0;
            data_prot <= '0;
        end else if (frame_start) begin
            byte_cnt <= '0;
        end else if (rx_valid) begin
            if (byte_cnt == 2'd0) opcode <= rx_byte;
            if (byte_cnt == 2'd1) begin
                data_lock <= rx_byte[7];
                data_prot <= rx_byte[3:2];
            end
            if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
        end
    end

    // Reply request: every byte boundary of a read-status frame.
    always_comb begin
        if (byte_cnt == 2'd0) tx_load = rx_valid && (rx_byte == OP_READ_STATUS);
        else                  tx_load = rx_valid && (opcode == OP_READ_STATUS);
    end

    // Classification of the finished frame by opcode and byte count.
    always_comb begin
        kind_c = CMD_NONE;
        if (opcode == OP_WRITE_ENABLE && byte_cnt == 2'd1)      kind_c = CMD_WREN;
        else if (opcode == OP_STATUS_EN && byte_cnt == 2'd1)    kind_c = CMD_SEN;
        else if (opcode == OP_WRITE_STATUS && byte_cnt >= 2'd2) kind_c = CMD_WRSTAT;
    end

    // Registered command strobe toward the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_NONE;
            cmd_lock  <= 1'b0;
            cmd_prot  <= '0;
        end else begin
            cmd_valid <= frame_end;
            cmd_kind  <= kind_c;
            cmd_lock  <= data_lock;
            cmd_prot  <= data_prot;
        end
    end

    // R4: a command strobe lasts exactly one cycle.
    p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

// File: rtl/sfsg_status_regs.sv
// Status register with write-protection rules and a self-timed busy period.
// Assumes one command strobe at a time; hw protect pin is asynchronous.
module sfsg_status_regs #(
    parameter sfsg_pkg::enable_mode_e ENABLE_MODE = sfsg_pkg::EN_BY_WREN,
    parameter int BUSY_CYCLES = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hw_protect_n,
    input  logic                        cmd_valid,
    input  sfsg_pkg::cmd_kind_e         cmd_kind,
    input  logic                        cmd_lock,
    input  logic [1:0]                  cmd_prot,
    output logic [sfsg_pkg::BYTE_W-1:0] status
);
    import sfsg_pkg::*;

    localparam int   CNT_W      = $clog2(BUSY_CYCLES + 1);
    localparam logic ALLOW_WREN = (ENABLE_MODE != EN_BY_STATUS);
    localparam logic ALLOW_SEN  = (ENABLE_MODE != EN_BY_WREN);

    logic [SYNC_STAGES-1:0] wp_p;
    logic                   wp_s;
    logic                   lock_q, err_q, wel_q, sen_q, busy_q;
    logic [1:0]             prot_q;
    logic                   pend_lock;
    logic [1:0]             pend_prot;
    logic [CNT_W-1:0]       cnt_q;
    logic                   wr_enabled, wr_refused;
    logic                   next_lock;
    logic [1:0]             next_prot;

    // Protect pin synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) wp_p <= '1;
        else        wp_p <= {wp_p[SYNC_STAGES-2:0], hw_protect_n};
    end
    assign wp_s = wp_p[SYNC_STAGES-1];

    // Write admission and the field values an admitted write would commit.
    always_comb begin
        wr_enabled = (ALLOW_WREN && wel_q) || (ALLOW_SEN && sen_q);
        wr_refused = lock_q && !cmd_lock && !wp_s;
        next_lock  = cmd_lock;
        if (lock_q)                  next_prot = prot_q;
        else if (cmd_prot == 2'b00)  next_prot = 2'b00;
        else if (cmd_prot == 2'b11)  next_prot = 2'b11;
        else                         next_prot = prot_q;
    end

    // Command execution, busy timer and commit at the end of the busy period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= 1'b0;
            prot_q    <= 2'b11;
            err_q     <= 1'b0;
            wel_q     <= 1'b0;
            sen_q     <= 1'b0;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            pend_lock <= 1'b0;
            pend_prot <= 2'b11;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
                err_q  <= 1'b0;
                lock_q <= pend_lock;
                prot_q <= pend_prot;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (cmd_valid) begin
            case (cmd_kind)
                CMD_WREN: wel_q <= 1'b1;
                CMD_SEN:  if (ALLOW_SEN) sen_q <= 1'b1;
                CMD_WRSTAT: begin
                    sen_q <= 1'b0;
                    if (!wr_enabled) begin
                        wel_q <= 1'b0;
                    end else if (wr_refused) begin
                        wel_q <= 1'b0;
                        err_q <= 1'b1;
                    end else begin
                        busy_q    <= 1'b1;
                        cnt_q     <= CNT_W'(BUSY_CYCLES - 1);
                        pend_lock <= next_lock;
                        pend_prot <= next_prot;
                    end
                end
                default: ;
            endcase
        end
    end

    assign status = {lock_q, 1'b0, err_q, wp_s, prot_q, wel_q, busy_q};

    // R8: a set lock keeps the protection field frozen.
    p_lock_freezes_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (prot_q == $past(prot_q)));
    // R8: the lock only drops when a self-timed write completes.
    p_lock_drop_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $fell(busy_q));
    // R5: busy only starts when an enabling command preceded it.
    p_busy_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(wel_q || sen_q));
    // R6: the write-enable latch is clear once busy ends.
    p_wel_clear_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> !wel_q);
    // R6: the timer stays inside its window while busy.
    p_busy_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CNT_W'(BUSY_CYCLES)));
    // R9: a refusal never starts the busy period.
    p_refuse_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !busy_q);
endmodule

// File: rtl/sflash_status_guard.sv
// Top: serial flash status register with protection rules behind an SPI
// mode-0 target. Assumes clk is much faster than spi_sck.
module sflash_status_guard #(
    parameter sfsg_pkg::enable_mode_e ENABLE_MODE = sfsg_pkg::EN_BY_WREN,
    parameter int BUSY_CYCLES = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic hw_protect_n,
    output logic spi_miso
);
    import sfsg_pkg::*;

    logic              frame_start, frame_end, rx_valid, tx_load;
    logic [BYTE_W-1:0] rx_byte, status;
    logic              cmd_valid, cmd_lock;
    cmd_kind_e         cmd_kind;
    logic [1:0]        cmd_prot;

    sfsg_spi_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk(clk), .rst_n(rst_n),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_load(tx_load), .tx_byte(status), .miso(spi_miso),
        .frame_start(frame_start), .frame_end(frame_end),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    sfsg_cmd_decode u_decode (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_load(tx_load), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_lock(cmd_lock), .cmd_prot(cmd_prot)
    );

    sfsg_status_regs #(
        .ENABLE_MODE(ENABLE_MODE), .BUSY_CYCLES(BUSY_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_protect_n(hw_protect_n),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_lock(cmd_lock), .cmd_prot(cmd_prot), .status(status)
    );
endmodule

// File: tb/sflash_status_guard_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module sflash_status_guard_tb;
    localparam int BUSY = 600;
    localparam int HALF = 8;
    localparam int GAP  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    wire  miso;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] txb [4];
    logic [7:0] rxb [4];

    always #2 clk = ~clk;

    sflash_status_guard #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .hw_protect_n(wp_n), .spi_miso(miso)
    );

    function automatic logic [7:0] mk(input logic lock, input logic err,
            input logic wp, input logic [1:0] prot, input logic wel, input logic busy);
        return {lock, 1'b0, err, wp, prot, wel, busy};
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic spi_frame(input int nbytes);
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = txb[b][i];
                repeat (HALF) @(negedge clk);
                rxb[b][i] = miso;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic rd_status(output logic [7:0] s);
        txb[0] = 8'h05; txb[1] = 8'h00;
        spi_frame(2);
        s = rxb[1];
    endtask

    task automatic op1(input logic [7:0] op);
        txb[0] = op;
        spi_frame(1);
    endtask

    task automatic wr_status(input logic [7:0] d);
        txb[0] = 8'h01; txb[1] = d;
        spi_frame(2);
    endtask

    task automatic wait_idle();
        repeat (BUSY + 40) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rd_status(s);
        check(s, 8'h1C, "R1 reset value");
    endtask

    task automatic t_repeat_read();
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
        spi_frame(4);
        check(rxb[0], 8'h00, "R2 opcode byte phase");
        check(rxb[1], 8'h1C, "R2 first status byte");
        check(rxb[2], 8'h1C, "R2 repeated status byte 2");
        check(rxb[3], 8'h1C, "R2 repeated status byte 3");
    endtask

    task automatic t_pin_reflect();
        logic [7:0] s;
        wp_n = 1'b0; repeat (10) @(negedge clk);
        rd_status(s);
        check(s, mk(0, 0, 0, 2'b11, 0, 0), "R3 pin low");
        wp_n = 1'b1; repeat (10) @(negedge clk);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b11, 0, 0), "R3 pin high");
    endtask

    task automatic t_unprotect();
        logic [7:0] s;
        op1(8'h06);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b11, 1, 0), "R4 latch set");
        wr_status(8'h00);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b11, 1, 1), "R6 busy with old value");
        wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R6 R7 global unprotect committed");
    endtask

    task automatic t_not_enabled();
        logic [7:0] s;
        wr_status(8'h0C);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R5 write without enable");
        op1(8'h50);
        wr_status(8'h0C);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R5 status-enable not allowed in mode 0");
    endtask

    task automatic t_reserved_field();
        logic [7:0] s;
        op1(8'h06); wr_status(8'h08); wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R7 code 10 ignored");
        op1(8'h06); wr_status(8'h04); wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R7 code 01 ignored");
        op1(8'h06); wr_status(8'h0C); wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b11, 0, 0), "R7 global protect");
    endtask

    task automatic t_busy_ignore();
        logic [7:0] s;
        op1(8'h06);
        wr_status(8'h00);
        wr_status(8'h0C);
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b11, 1, 1), "R10 read while busy");
        wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R10 write during busy ignored");
    endtask

    task automatic t_lock();
        logic [7:0] s;
        op1(8'h06); wr_status(8'h80); wait_idle();
        rd_status(s);
        check(s, mk(1, 0, 1, 2'b00, 0, 0), "R8 lock set");
        op1(8'h06); wr_status(8'h8C); wait_idle();
        rd_status(s);
        check(s, mk(1, 0, 1, 2'b00, 0, 0), "R8 field frozen while locked");
        wp_n = 1'b0; repeat (10) @(negedge clk);
        op1(8'h06); wr_status(8'h00);
        rd_status(s);
        check(s, mk(1, 1, 0, 2'b00, 0, 0), "R9 unlock refused, no busy");
        wait_idle();
        rd_status(s);
        check(s, mk(1, 1, 0, 2'b00, 0, 0), "R9 register unchanged");
        wp_n = 1'b1; repeat (10) @(negedge clk);
        op1(8'h06); wr_status(8'h0C); wait_idle();
        rd_status(s);
        check(s, mk(0, 0, 1, 2'b00, 0, 0), "R8 unlock only touches bit 7");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_repeat_read();
        t_pin_reflect();
        t_unprotect();
        t_not_enabled();
        t_reserved_field();
        t_busy_ignore();
        t_lock();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule